// File: doc/BRIEF.md
# Block Copy and Block Compare Sequencer

This block carries out the string move and string search operations of an 8-bit processor core. When it accepts a start request it takes a working copy of three 16-bit registers: a source pointer (HL), a destination pointer (DE) and a byte counter (BC). It also takes the accumulator and the incoming flag byte. It then runs one or more iterations against a synchronous memory port. A copy iteration reads the byte at the source pointer and writes it to the destination pointer. A compare iteration reads the byte at the source pointer and subtracts it from the accumulator, and the result only sets flags.

The operation comes from the second byte of an escape-prefixed opcode. Bit 0 of that byte picks compare over copy, bit 3 makes the pointers step downwards, and bit 4 repeats the iteration until its stop condition holds. When the operation ends, the block pulses `done` for one clock. The updated registers, the flags and the total clock-cycle cost are then on its outputs. A request to service an interrupt can stop a repeating operation between iterations. The block then reports that the instruction must be fetched and run again.

Top module: `blk_xfer_seq`

## Requirements
- R1: Only the opcodes 0xA0, 0xA1, 0xA8, 0xA9, 0xB0, 0xB1, 0xB8 and 0xB9 are accepted. In these, bit 0 = 1 selects compare, bit 3 = 1 selects decrement and bit 4 = 1 selects repeat. A start request with any other opcode is ignored: busy stays low and no done follows.
- R2: A copy iteration reads the byte at HL and writes it to address DE. It then moves HL and DE by +1 (bit 3 = 0) or -1 (bit 3 = 1) and lowers BC by one, wrapping at 16 bits.
- R3: A compare iteration reads the byte at HL and forms A minus that byte for the flags only. It writes no memory, moves HL by +1 or -1 as for a copy, leaves DE unchanged and lowers BC by one.
- R4: A repeating copy keeps iterating until BC becomes zero after its decrement, and it ends with the P/V flag clear.
- R5: A repeating compare stops after the iteration in which the byte equals A or BC becomes zero, whichever comes first.
- R6: Copy flags: H = 0, N = 0, and P/V = 1 when BC after the decrement is nonzero. Bits 7, 6, 5, 3 and 0 keep their input values. The flag bit positions are S = 7, Z = 6, H = 4, P/V = 2, N = 1 and C = 0.
- R7: Compare flags: S = bit 7 of the difference, and Z = 1 when the difference is zero. H = 1 when the low nibble of A is below the low nibble of the byte. P/V = 1 when BC after the decrement is nonzero, and N = 1. C, bit 5 and bit 3 keep their input values.
- R8: An iteration that is followed by another costs 21 cycles, and the final iteration costs 16. The cycle output is cleared at start and holds the total cost at done.
- R9: A BC of zero at start is not a stop: it wraps to 0xFFFF and the operation goes on, which gives 65536 iterations.
- R10: done is high for exactly one clock at completion, and busy is high from the clock after an accepted start until that clock.
- R11: A start request while busy is ignored. The running operation completes with the results it would have had without that request.
- R12: If int_req is high when a repeating iteration would go on, the operation ends after that iteration. It raises reexec with done, the registers and flags reflect the iterations already completed, and that iteration is counted at 21 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation |
| opcode | input | 8 | Second opcode byte, sampled at start |
| hl_in | input | 16 | Source pointer at start |
| de_in | input | 16 | Destination pointer at start |
| bc_in | input | 16 | Byte counter at start |
| acc | input | 8 | Accumulator for compares, sampled at start |
| flags_in | input | 8 | Flag byte at start |
| int_req | input | 1 | Pending interrupt; ends a repeat between iterations |
| mem_rdata | input | 8 | Read data, valid the clock after mem_re |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| reexec | output | 1 | Operation was interrupted and must be run again |
| hl_out | output | 16 | Current source pointer |
| de_out | output | 16 | Current destination pointer |
| bc_out | output | 16 | Current byte counter |
| flags_out | output | 8 | Current flag byte |
| cycles_out | output | 24 | Cycle cost of the current or last operation |

## Verification
Single copies are run both upward and downward, with all flags set and with all flags clear. This shows that only H, N and P/V move, and that P/V follows the count reaching zero. Repeating copies are run in both directions over several bytes, and the memory contents and the summed cycle cost tell a 21-cycle iteration from a 16-cycle one. Compares are run with a match, with a nibble borrow and a negative result, with an early match in a repeat, and with a repeat that runs out of count. These separate the two stop conditions. An invalid opcode, a start while busy, and an interrupted repeat started with a zero count each check an input that must be ignored or must cut the operation short.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int FL_S  = 7;
  localparam int FL_Z  = 6;
  localparam int FL_H  = 4;
  localparam int FL_PV = 2;
  localparam int FL_N  = 1;
  localparam int FL_C  = 0;

  typedef struct packed {
    logic valid;
    logic is_cmp;
    logic dec;
    logic rep;
  } bx_op_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_CAPT = 2'd2,
    ST_ACT  = 2'd3
  } bx_state_t;
endpackage

// File: rtl/bx_decode.sv
module bx_decode
  import bx_pkg::*;
(
  input  logic [7:0] opcode,
  output bx_op_t     op
);
  always_comb begin
    op.valid  = (opcode[7:5] == 3'b101) && (opcode[2:1] == 2'b00);
    op.is_cmp = opcode[0];
    op.dec    = opcode[3];
    op.rep    = opcode[4];
  end
endmodule

// File: rtl/bx_step.sv
module bx_step
  import bx_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] hl,
  input  logic [AW-1:0] de,
  input  logic [AW-1:0] bc,
  input  logic          dec,
  input  logic          is_cmp,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] mbyte,
  input  logic [7:0]    flags_old,
  output logic [AW-1:0] hl_nx,
  output logic [AW-1:0] de_nx,
  output logic [AW-1:0] bc_nx,
  output logic [7:0]    flags_nx,
  output logic          stop
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [DW-1:0] diff;
  logic          bc_nz;

  always_comb begin
    hl_nx = dec ? hl - ONE : hl + ONE;
    de_nx = is_cmp ? de : (dec ? de - ONE : de + ONE);
    bc_nx = bc - ONE;
    bc_nz = (bc_nx != '0);
    diff  = acc - mbyte;

    flags_nx        = flags_old;
    flags_nx[FL_PV] = bc_nz;
    if (is_cmp) begin
      flags_nx[FL_S] = diff[DW-1];
      flags_nx[FL_Z] = (diff == '0);
      flags_nx[FL_H] = (acc[3:0] < mbyte[3:0]);
      flags_nx[FL_N] = 1'b1;
    end else begin
      flags_nx[FL_H] = 1'b0;
      flags_nx[FL_N] = 1'b0;
    end
    stop = !bc_nz || (is_cmp && (diff == '0));
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import bx_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int CW        = 24,
  parameter int REP_COST  = 21,
  parameter int LAST_COST = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [AW-1:0] hl_in,
  input  logic [AW-1:0] de_in,
  input  logic [AW-1:0] bc_in,
  input  logic [DW-1:0] acc,
  input  logic [7:0]    flags_in,
  input  logic          int_req,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          done,
  output logic          reexec,
  output logic [AW-1:0] hl_out,
  output logic [AW-1:0] de_out,
  output logic [AW-1:0] bc_out,
  output logic [7:0]    flags_out,
  output logic [CW-1:0] cycles_out
);
  localparam logic [CW-1:0] C_REP  = CW'(REP_COST);
  localparam logic [CW-1:0] C_LAST = CW'(LAST_COST);

  bx_state_t     state;
  bx_op_t        op_in, op_q;
  logic [AW-1:0] hl_q, de_q, bc_q;
  logic [AW-1:0] hl_nx, de_nx, bc_nx;
  logic [7:0]    flags_q, flags_nx;
  logic [DW-1:0] acc_q, data_q;
  logic [CW-1:0] cyc_q;
  logic          done_q, reexec_q, stop, go_on;

  bx_decode u_dec (.opcode(opcode), .op(op_in));

  bx_step #(.AW(AW), .DW(DW)) u_step (
    .hl(hl_q), .de(de_q), .bc(bc_q), .dec(op_q.dec), .is_cmp(op_q.is_cmp),
    .acc(acc_q), .mbyte(data_q), .flags_old(flags_q),
    .hl_nx(hl_nx), .de_nx(de_nx), .bc_nx(bc_nx), .flags_nx(flags_nx), .stop(stop)
  );

  assign go_on = op_q.rep && !stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_q     <= '0;
      hl_q     <= '0;
      de_q     <= '0;
      bc_q     <= '0;
      flags_q  <= '0;
      acc_q    <= '0;
      data_q   <= '0;
      cyc_q    <= '0;
      done_q   <= 1'b0;
      reexec_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start && op_in.valid) begin
            state    <= ST_READ;
            op_q     <= op_in;
            hl_q     <= hl_in;
            de_q     <= de_in;
            bc_q     <= bc_in;
            flags_q  <= flags_in;
            acc_q    <= acc;
            cyc_q    <= '0;
            reexec_q <= 1'b0;
          end
        end
        ST_READ: state <= ST_CAPT;
        ST_CAPT: begin
          data_q <= mem_rdata;
          state  <= ST_ACT;
        end
        ST_ACT: begin
          hl_q    <= hl_nx;
          de_q    <= de_nx;
          bc_q    <= bc_nx;
          flags_q <= flags_nx;
          cyc_q   <= cyc_q + (go_on ? C_REP : C_LAST);
          if (go_on && !int_req) begin
            state <= ST_READ;
          end else begin
            state    <= ST_IDLE;
            done_q   <= 1'b1;
            reexec_q <= go_on;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = (state != ST_IDLE);
    mem_re     = (state == ST_READ);
    mem_we     = (state == ST_ACT) && !op_q.is_cmp;
    mem_addr   = (state == ST_ACT) ? de_q : hl_q;
    mem_wdata  = data_q;
    done       = done_q;
    reexec     = reexec_q;
    hl_out     = hl_q;
    de_out     = de_q;
    bc_out     = bc_q;
    flags_out  = flags_q;
    cycles_out = cyc_q;
  end
endmodule

// File: rtl/bx_chk.sv
module bx_chk
  import bx_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 24,
  parameter int LAST_COST = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          reexec,
  input logic          mem_re,
  input logic          mem_we,
  input logic [AW-1:0] bc_out,
  input logic [7:0]    flags_out,
  input logic [CW-1:0] cycles_out,
  input logic          op_rep,
  input logic          op_cmp
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_end_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  assert_no_clash_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !mem_re);
  assert_cmp_nowrite_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !op_cmp);
  assert_repcopy_end_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !reexec && op_rep && !op_cmp) |-> (bc_out == '0 && !flags_out[FL_PV]));
  assert_cycles_min_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycles_out >= CW'(LAST_COST)));
  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> (busy || done));
  assert_reexec_done_R12: assert property (@(posedge clk) disable iff (rst)
    reexec |-> (done || !busy));
  assert_reexec_pv_R12: assert property (@(posedge clk) disable iff (rst)
    (done && reexec) |-> flags_out[FL_PV]);
endmodule

bind blk_xfer_seq bx_chk #(.AW(AW), .CW(CW), .LAST_COST(LAST_COST)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .reexec(reexec),
  .mem_re(mem_re), .mem_we(mem_we), .bc_out(bc_out), .flags_out(flags_out),
  .cycles_out(cycles_out), .op_rep(op_q.rep), .op_cmp(op_q.is_cmp)
);

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] hl_in = '0, de_in = '0, bc_in = '0;
  logic [7:0]  acc = '0, flags_in = '0;
  logic        int_req = 1'b0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, hl_out, de_out, bc_out;
  logic        mem_re, mem_we, busy, done, reexec;
  logic [7:0]  mem_wdata, flags_out;
  logic [23:0] cycles_out;
  logic [7:0]  mem [0:255];
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  blk_xfer_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .hl_in(hl_in),
    .de_in(de_in), .bc_in(bc_in), .acc(acc), .flags_in(flags_in),
    .int_req(int_req), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .busy(busy),
    .done(done), .reexec(reexec), .hl_out(hl_out), .de_out(de_out),
    .bc_out(bc_out), .flags_out(flags_out), .cycles_out(cycles_out)
  );

  always_ff @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [7:0] op, input logic [15:0] hl, input logic [15:0] de,
                      input logic [15:0] bc, input logic [7:0] a, input logic [7:0] f);
    @(negedge clk);
    start = 1'b1; opcode = op; hl_in = hl; de_in = de; bc_in = bc; acc = a; flags_in = f;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R10 done seen", done, 1);
    @(negedge clk);
    chk("R10 done one clock", {done, busy}, 2'b00);
  endtask

  task automatic t_reset();
    chk("R10 reset idle", {busy, done, reexec, mem_we, mem_re}, 5'b0);
    chk("R8 reset cycles", cycles_out, 0);
  endtask

  task automatic t_copy_inc();
    mem[8'h10] = 8'h5A;
    kick(8'hA0, 16'h0010, 16'h0040, 16'h0002, 8'h00, 8'hFF);
    chk("R10 busy after start", busy, 1);
    wait_done();
    chk("R2 dest byte", mem[8'h40], 8'h5A);
    chk("R2 pointers up", {hl_out, de_out, bc_out}, {16'h0011, 16'h0041, 16'h0001});
    chk("R6 copy flags all set", flags_out, 8'hED);
    chk("R8 single cost", cycles_out, 16);
  endtask

  task automatic t_copy_dec();
    mem[8'h20] = 8'hC3;
    kick(8'hA8, 16'h0020, 16'h0050, 16'h0001, 8'h00, 8'h00);
    wait_done();
    chk("R2 dest byte down", mem[8'h50], 8'hC3);
    chk("R2 pointers down", {hl_out, de_out, bc_out}, {16'h001F, 16'h004F, 16'h0000});
    chk("R6 copy flags pv clear", flags_out, 8'h00);
  endtask

  task automatic t_copy_rep_inc();
    for (int i = 0; i < 4; i++) mem[8'h60 + i] = 8'h11 * (i + 1);
    kick(8'hB0, 16'h0060, 16'h0080, 16'h0004, 8'h00, 8'h00);
    wait_done();
    for (int i = 0; i < 4; i++) chk("R4 rep copy byte", mem[8'h80 + i], 8'h11 * (i + 1));
    chk("R4 rep copy regs", {hl_out, de_out, bc_out}, {16'h0064, 16'h0084, 16'h0000});
    chk("R4 rep copy pv", flags_out, 8'h00);
    chk("R8 rep cost 3x21+16", cycles_out, 79);
  endtask

  task automatic t_copy_rep_dec();
    for (int i = 0; i < 3; i++) mem[8'h71 + i] = 8'hA0 + i;
    kick(8'hB8, 16'h0073, 16'h0093, 16'h0003, 8'h00, 8'h00);
    wait_done();
    for (int i = 0; i < 3; i++) chk("R4 rep copy down byte", mem[8'h91 + i], 8'hA0 + i);
    chk("R4 rep copy down regs", {hl_out, de_out, bc_out}, {16'h0070, 16'h0090, 16'h0000});
    chk("R8 rep down cost", cycles_out, 58);
  endtask

  task automatic t_cmp_single();
    mem[8'h30] = 8'h30;
    mem[8'h31] = 8'h77;
    kick(8'hA1, 16'h0030, 16'h0031, 16'h0005, 8'h30, 8'h01);
    wait_done();
    chk("R7 cmp match flags", flags_out, 8'h47);
    chk("R3 cmp regs", {hl_out, de_out, bc_out}, {16'h0031, 16'h0031, 16'h0004});
    chk("R3 cmp no write", mem[8'h31], 8'h77);
    mem[8'h38] = 8'h21;
    kick(8'hA9, 16'h0038, 16'h0099, 16'h0001, 8'h10, 8'h00);
    wait_done();
    chk("R7 cmp neg borrow flags", flags_out, 8'h92);
    chk("R3 cmp down regs", {hl_out, de_out, bc_out}, {16'h0037, 16'h0099, 16'h0000});
  endtask

  task automatic t_cmp_rep_match();
    mem[8'hA0] = 8'h01; mem[8'hA1] = 8'h02; mem[8'hA2] = 8'h07; mem[8'hA3] = 8'h09;
    kick(8'hB1, 16'h00A0, 16'h0000, 16'd10, 8'h07, 8'h00);
    wait_done();
    chk("R5 match stop regs", {hl_out, bc_out}, {16'h00A3, 16'h0007});
    chk("R5 match flags", flags_out, 8'h46);
    chk("R8 match cost", cycles_out, 58);
  endtask

  task automatic t_cmp_rep_count();
    mem[8'hB0] = 8'h01; mem[8'hB1] = 8'h02; mem[8'hB2] = 8'h03;
    kick(8'hB9, 16'h00B2, 16'h0000, 16'h0003, 8'hFF, 8'h00);
    wait_done();
    chk("R5 count stop regs", {hl_out, bc_out}, {16'h00AF, 16'h0000});
    chk("R5 count flags", flags_out, 8'h82);
    chk("R8 count cost", cycles_out, 58);
  endtask

  task automatic t_invalid();
    kick(8'hA2, 16'h0010, 16'h0011, 16'h0001, 8'h00, 8'h00);
    chk("R1 invalid not busy", busy, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 invalid no done", {busy, done}, 2'b00);
    end
  endtask

  task automatic t_start_busy();
    for (int i = 0; i < 4; i++) mem[8'hC0 + i] = 8'h3C + i;
    kick(8'hB0, 16'h00C0, 16'h00D0, 16'h0004, 8'h00, 8'h00);
    @(negedge clk);
    start = 1'b1; opcode = 8'hA0; hl_in = 16'h0010; de_in = 16'h00E0; bc_in = 16'h0009;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R11 regs unchanged", {hl_out, de_out, bc_out}, {16'h00C4, 16'h00D4, 16'h0000});
    chk("R11 last byte", mem[8'hD3], 8'h3F);
    chk("R11 cost", cycles_out, 79);
  endtask

  task automatic t_interrupt();
    mem[8'hE0] = 8'h66;
    mem[8'hF0] = 8'h00;
    int_req = 1'b1;
    kick(8'hB0, 16'h00E0, 16'h00F0, 16'h0000, 8'h00, 8'h00);
    while (!done) @(negedge clk);
    chk("R12 reexec", reexec, 1);
    chk("R9 bc wraps", bc_out, 16'hFFFF);
    chk("R12 regs", {hl_out, de_out}, {16'h00E1, 16'h00F1});
    chk("R12 flags pv", flags_out, 8'h04);
    chk("R12 cost", cycles_out, 21);
    chk("R12 copied", mem[8'hF0], 8'h66);
    int_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_copy_inc();
    t_copy_dec();
    t_copy_rep_inc();
    t_copy_rep_dec();
    t_cmp_single();
    t_cmp_rep_match();
    t_cmp_rep_count();
    t_invalid();
    t_start_busy();
    t_interrupt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule